// File: doc/BRIEF.md
# Prescaled Auto-Reload Up-Counting Timer

This block is a general-purpose timer that a processor drives through a single-cycle register bus. A 16-bit prescaler divides the input clock. Each divided tick advances an up-counter by one. When the counter has reached the reload value, the next tick returns it to zero. If interrupts are enabled, that same tick raises a sticky update flag and a one-cycle interrupt pulse.

Software can read and write the counter at any time. An event-generation register can zero the counter. Clearing a status flag uses AND semantics: a written 0 clears the flag and a written 1 keeps it.

A further group of registers only stores and returns data: a second control register, slave mode, two mode registers, capture enable, four compare registers, DMA control, DMA address and option. They are storage for the software model only. They drive no logic.

Register map (byte offsets, low two address bits ignored):

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | control-2 |
| 0x08 | slave mode |
| 0x0C | interrupt enable |
| 0x10 | status |
| 0x14 | event |
| 0x18 | mode-1 |
| 0x1C | mode-2 |
| 0x20 | capture enable |
| 0x24 | counter |
| 0x28 | prescaler |
| 0x2C | reload |
| 0x34, 0x38, 0x3C, 0x40 | compare 0 to 3 |
| 0x48 | DMA control |
| 0x4C | DMA address |
| 0x50 | option |

Top module: `ptimer_top`

## Requirements
- R1: While control bit 0 (enable, offset 0x00) is 1, the counter advances by one every PSC+1 clock cycles, where PSC is the prescaler (offset 0x28). A running counter read twice k·(PSC+1) cycles apart differs by k.
- R2: A prescaler write stores only the low 16 bits of the data. A prescaler write leaves the counter value unchanged.
- R3: On a tick where the counter equals the reload value R (offset 0x2C), the counter goes to zero. If interrupt-enable bit 0 (offset 0x0C) is set on that tick, two more things happen: status bit 0 (offset 0x10) becomes 1, and `irq_pulse` is high for exactly one cycle, in the cycle after that tick. With the timer running, consecutive pulses are (R+1)·(PSC+1) cycles apart.
- R4: A status write ANDs the stored flag with data bit 0. Writing 0 clears the flag and writing 1 keeps it.
- R5: Writing the event register (offset 0x14) with bit 0 set loads the counter with zero. The event register always reads zero.
- R6: The counter (offset 0x24) can be written directly, and counting continues from the written value. While enable is 0 the counter holds.
- R7: While the reload value is zero, no interrupt pulse and no status flag are produced.
- R8: After reset every register reads zero and `irq_pulse` is low.
- R9: The storage-only registers return the value written to them. Reads of offsets not in the map return zero, and writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte address within the register window |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pulse | output | 1 | One-cycle update interrupt |

## Verification
The spacing of interrupt pulses depends on two values at once: the prescaler phase and the counter position relative to the reload value. Reaching a known steady period from the ports therefore needs a fixed sequence. The bench disables the timer, loads the prescaler and reload value, and writes the counter to zero, which also restarts the prescaler phase. It then enables interrupts and the timer, and measures the gap between the second and third pulses over a sweep of small prescaler and reload values. The rule that a prescaler change keeps the count is checked while the timer is stopped, so that no tick can mask a change to the counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int PSC_W  = 16;
  localparam int NUM_CMP = 4;
  localparam int WIDX_W = ADDR_W - 2;

  // word indices (byte offset / 4)
  localparam logic [WIDX_W-1:0] W_CTRL   = 8'd0;
  localparam logic [WIDX_W-1:0] W_CTRL2  = 8'd1;
  localparam logic [WIDX_W-1:0] W_SMODE  = 8'd2;
  localparam logic [WIDX_W-1:0] W_IEN    = 8'd3;
  localparam logic [WIDX_W-1:0] W_STAT   = 8'd4;
  localparam logic [WIDX_W-1:0] W_EVT    = 8'd5;
  localparam logic [WIDX_W-1:0] W_MODE1  = 8'd6;
  localparam logic [WIDX_W-1:0] W_MODE2  = 8'd7;
  localparam logic [WIDX_W-1:0] W_CAPEN  = 8'd8;
  localparam logic [WIDX_W-1:0] W_COUNT  = 8'd9;
  localparam logic [WIDX_W-1:0] W_PSC    = 8'd10;
  localparam logic [WIDX_W-1:0] W_RELOAD = 8'd11;
  localparam logic [WIDX_W-1:0] W_CMP0   = 8'd13;
  localparam logic [WIDX_W-1:0] W_DCTL   = 8'd18;
  localparam logic [WIDX_W-1:0] W_DADDR  = 8'd19;
  localparam logic [WIDX_W-1:0] W_OPT    = 8'd20;

  // next counter value on a tick: wrap after reaching the reload value
  function automatic logic [CNT_W-1:0] fn_next_cnt(input logic [CNT_W-1:0] cur,
                                                   input logic [CNT_W-1:0] rld);
    return (cur == rld) ? '0 : cur + 1'b1;
  endfunction

  // prescaler phase has reached its terminal value
  function automatic logic fn_psc_done(input logic [PSC_W-1:0] phase,
                                       input logic [PSC_W-1:0] div);
    return phase >= div;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int P_W = PSC_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           restart,
  input  logic [P_W-1:0] div,
  output logic           tick
);
  logic [P_W-1:0] phase_q;

  assign tick = run && (phase_q >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)        phase_q <= '0;
    else if (restart)  phase_q <= '0;
    else if (tick)     phase_q <= '0;
    else if (run)      phase_q <= phase_q + 1'b1;
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(phase_q)) else $error("phase moved while stopped"); // R6
  AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase_q == '0)) else $error("phase not restarted"); // R1
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int C_W = CNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [C_W-1:0] rld,
  input  logic           ld,
  input  logic [C_W-1:0] ld_val,
  output logic [C_W-1:0] cnt,
  output logic           wrap
);
  logic [C_W-1:0] cnt_q;

  assign cnt  = cnt_q;
  assign wrap = tick && !ld && (cnt_q == rld) && (rld != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (ld)    cnt_q <= ld_val;
    else if (tick)  cnt_q <= fn_next_cnt(cnt_q, rld);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && cnt_q != rld) |=> (cnt_q == C_W'($past(cnt_q) + 1'b1))) else $error("bad step"); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt_q)) else $error("counter moved"); // R6
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val))) else $error("load lost"); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0)) else $error("no wrap"); // R3
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag_set,
  output logic              run,
  output logic              upd_ien,
  output logic [PSC_W-1:0]  div,
  output logic [CNT_W-1:0]  rld,
  output logic              cnt_ld,
  output logic [CNT_W-1:0]  cnt_ld_val
);
  logic [WIDX_W-1:0] widx;
  logic [DATA_W-1:0] ctrl_q, ctrl2_q, smode_q, ien_q, mode1_q, mode2_q, capen_q;
  logic [DATA_W-1:0] dctl_q, daddr_q, opt_q;
  logic [DATA_W-1:0] cmp_q [NUM_CMP];
  logic              flag_q;
  logic [PSC_W-1:0]  div_q;
  logic [CNT_W-1:0]  rld_q;
  logic              wr_stat, wr_evt, wr_cnt;
  logic [DATA_W-1:0] cmp_rd;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign wr_stat = bus_we && (widx == W_STAT);
  assign wr_evt  = bus_we && (widx == W_EVT) && bus_wdata[0];
  assign wr_cnt  = bus_we && (widx == W_COUNT);

  assign run        = ctrl_q[0];
  assign upd_ien    = ien_q[0];
  assign div        = div_q;
  assign rld        = rld_q;
  assign cnt_ld     = wr_cnt || wr_evt;
  assign cnt_ld_val = wr_cnt ? bus_wdata[CNT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; ctrl2_q <= '0; smode_q <= '0; ien_q <= '0;
      mode1_q <= '0; mode2_q <= '0; capen_q <= '0;
      dctl_q <= '0; daddr_q <= '0; opt_q <= '0;
      div_q <= '0; rld_q <= '0;
    end else if (bus_we) begin
      case (widx)
        W_CTRL:   ctrl_q  <= bus_wdata;
        W_CTRL2:  ctrl2_q <= bus_wdata;
        W_SMODE:  smode_q <= bus_wdata;
        W_IEN:    ien_q   <= bus_wdata;
        W_MODE1:  mode1_q <= bus_wdata;
        W_MODE2:  mode2_q <= bus_wdata;
        W_CAPEN:  capen_q <= bus_wdata;
        W_PSC:    div_q   <= bus_wdata[PSC_W-1:0];
        W_RELOAD: rld_q   <= bus_wdata[CNT_W-1:0];
        W_DCTL:   dctl_q  <= bus_wdata;
        W_DADDR:  daddr_q <= bus_wdata;
        W_OPT:    opt_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  // hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (flag_set) flag_q <= 1'b1;
    else if (wr_stat)  flag_q <= flag_q & bus_wdata[0];
  end

  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    localparam logic [WIDX_W-1:0] MY_IDX = W_CMP0 + WIDX_W'(gi);
    always_ff @(posedge clk) begin
      if (!rst_n)                        cmp_q[gi] <= '0;
      else if (bus_we && widx == MY_IDX) cmp_q[gi] <= bus_wdata;
    end
  end

  always_comb begin
    cmp_rd = '0;
    for (int i = 0; i < NUM_CMP; i++)
      if (widx == W_CMP0 + WIDX_W'(i)) cmp_rd = cmp_q[i];
  end

  always_comb begin
    case (widx)
      W_CTRL:   bus_rdata = ctrl_q;
      W_CTRL2:  bus_rdata = ctrl2_q;
      W_SMODE:  bus_rdata = smode_q;
      W_IEN:    bus_rdata = ien_q;
      W_STAT:   bus_rdata = DATA_W'(flag_q);
      W_MODE1:  bus_rdata = mode1_q;
      W_MODE2:  bus_rdata = mode2_q;
      W_CAPEN:  bus_rdata = capen_q;
      W_COUNT:  bus_rdata = DATA_W'(cnt);
      W_PSC:    bus_rdata = DATA_W'(div_q);
      W_RELOAD: bus_rdata = DATA_W'(rld_q);
      W_DCTL:   bus_rdata = dctl_q;
      W_DADDR:  bus_rdata = daddr_q;
      W_OPT:    bus_rdata = opt_q;
      default:  bus_rdata = cmp_rd;
    endcase
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> flag_q) else $error("flag not set"); // R3
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0]) |=> (flag_q || !$past(flag_q))) else $error("flag lost"); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bus_wdata[0] && !flag_set) |=> !flag_q) else $error("flag stuck"); // R4
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse
);
  logic             run, upd_ien, tick, wrap, cnt_ld, flag_set;
  logic [PSC_W-1:0] div;
  logic [CNT_W-1:0] rld, cnt, cnt_ld_val;
  logic             irq_q;

  tmr_regs u_regs (
    .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .cnt, .flag_set, .run, .upd_ien, .div, .rld, .cnt_ld, .cnt_ld_val
  );

  tmr_prescaler #(.P_W(PSC_W)) u_psc (
    .clk, .rst_n, .run, .restart(cnt_ld), .div, .tick
  );

  tmr_counter #(.C_W(CNT_W)) u_cnt (
    .clk, .rst_n, .tick, .rld, .ld(cnt_ld), .ld_val(cnt_ld_val), .cnt, .wrap
  );

  assign flag_set = wrap && upd_ien;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= flag_set;
  end
  assign irq_pulse = irq_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse) else $error("wide pulse"); // R3
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rld == '0) |=> !irq_pulse) else $error("event with zero reload"); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_ien || !run) |=> !irq_pulse) else $error("ungated irq"); // R3
  AST_PSC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[ADDR_W-1:2] == W_PSC && !tick) |=> $stable(cnt)) else $error("psc moved cnt"); // R2
endmodule

// File: tb/ptimer_top_tb_top.sv
module ptimer_top_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  a = '0;
  logic        we = 0;
  logic [31:0] d = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_cyc = 0, gap = 0, irq_cnt = 0, wide = 0;
  logic prev_irq = 0;

  ptimer_top dut_i (.clk, .rst_n, .bus_addr(a), .bus_we(we), .bus_wdata(d),
                    .bus_rdata(rdata), .irq_pulse(irq));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (prev_irq) wide++;
      gap = cyc - last_cyc;
      last_cyc = cyc;
      irq_cnt++;
    end
    prev_irq = irq;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] ad, logic [31:0] v);
    @(negedge clk); a = ad; d = v; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [9:0] ad, output logic [31:0] v);
    @(negedge clk); a = ad; #1 v = rdata;
  endtask

  task automatic wait_irq(int target);
    for (int i = 0; i < 2000 && irq_cnt < target; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] v, v1, v2;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset state
    for (int off = 0; off <= 'h50; off += 4) begin
      rd(10'(off), v);
      chk("R8", $sformatf("reset reg %0h", off), v, 0);
    end
    chk("R8", "irq low", {31'b0, irq}, 0);

    // R2: prescaler truncation and count kept
    wr(10'h024, 32'd7);
    wr(10'h028, 32'h0001_2345);
    rd(10'h028, v); chk("R2", "psc low 16", v, 32'h2345);
    rd(10'h024, v); chk("R2", "psc keeps cnt", v, 7);
    // R6: hold while disabled
    repeat (20) @(negedge clk);
    rd(10'h024, v); chk("R6", "hold disabled", v, 7);
    // R5: event forces zero, reads zero
    wr(10'h014, 32'h1);
    rd(10'h024, v); chk("R5", "event zero", v, 0);
    rd(10'h014, v); chk("R5", "event reads 0", v, 0);

    // R1/R6: running rate from a written value
    for (int p = 0; p < 4; p++) begin
      wr(10'h000, 0);
      wr(10'h028, p);
      wr(10'h02C, 1000);
      wr(10'h024, 10);
      wr(10'h000, 1);
      rd(10'h024, v1);
      repeat (5 * (p + 1)) @(negedge clk);
      #1 v2 = rdata;
      chk("R1", $sformatf("rate psc %0d", p), v2 - v1, 5);
      chk("R6", "resume from written", {31'b0, v1 >= 10 && v1 < 13}, 1);
    end

    // R3: period sweep
    for (int p = 0; p < 4; p++) begin
      for (int r = 1; r < 5; r++) begin
        wr(10'h000, 0);
        wr(10'h028, p);
        wr(10'h02C, r);
        wr(10'h024, 0);
        wr(10'h00C, 1);
        base = irq_cnt;
        wr(10'h000, 1);
        wait_irq(base + 3);
        chk("R3", $sformatf("period p%0d r%0d", p, r), gap, (r + 1) * (p + 1));
        wr(10'h000, 0);
        rd(10'h010, v); chk("R3", "flag set", v, 1);
        wr(10'h010, 32'h1);
        rd(10'h010, v); chk("R4", "write 1 keeps", v, 1);
        wr(10'h010, 32'hFFFF_FFFE);
        rd(10'h010, v); chk("R4", "write 0 clears", v, 0);
      end
    end
    chk("R3", "pulse width one", wide, 0);

    // R7: zero reload
    wr(10'h02C, 0); wr(10'h028, 0); wr(10'h024, 0);
    base = irq_cnt;
    wr(10'h000, 1);
    repeat (100) @(negedge clk);
    chk("R7", "no irq zero reload", irq_cnt - base, 0);
    rd(10'h010, v); chk("R7", "no flag zero reload", v, 0);

    // R3: interrupt enable off
    wr(10'h00C, 0); wr(10'h02C, 3);
    repeat (100) @(negedge clk);
    chk("R3", "no irq without enable", irq_cnt - base, 0);
    rd(10'h010, v); chk("R3", "no flag without enable", v, 0);
    wr(10'h000, 0);

    // R9: storage registers and unmapped offsets
    for (int k = 0; k < 12; k++) begin
      int offs[12] = '{'h04, 'h08, 'h18, 'h1C, 'h20, 'h34, 'h38, 'h3C, 'h40, 'h48, 'h4C, 'h50};
      wr(10'(offs[k]), 32'hA5000000 + k);
    end
    for (int k = 0; k < 12; k++) begin
      int offs[12] = '{'h04, 'h08, 'h18, 'h1C, 'h20, 'h34, 'h38, 'h3C, 'h40, 'h48, 'h4C, 'h50};
      rd(10'(offs[k]), v);
      chk("R9", $sformatf("store %0h", offs[k]), v, 32'hA5000000 + k);
    end
    wr(10'h030, 32'hDEAD); wr(10'h044, 32'hBEEF); wr(10'h3FC, 32'h1234);
    rd(10'h030, v); chk("R9", "unmapped 30", v, 0);
    rd(10'h044, v); chk("R9", "unmapped 44", v, 0);
    rd(10'h3FC, v); chk("R9", "unmapped 3fc", v, 0);
    rd(10'h02C, v); chk("R9", "reload untouched", v, 3);
    rd(10'h040, v); chk("R9", "cmp3 untouched", v, 32'hA5000008);
    summary();
  end
endmodule